// File: doc/BRIEF.md
# Subcarrier Divider with Window Phase Comparators

This block takes a clock running at eight times the colour subcarrier and divides it by eight. The result is an internal subcarrier phase reference. The moment the divider rolls over from its last count back to zero is the subcarrier phase event, called the tick. The block compares the tick against two pairs of gate pulses. The first pair is a pair of burst-rate gates. They drive two active-low burst phase outputs, and an enable input can hold both outputs inactive. The second pair is a pair of line-rate gates. They drive a registered early flag and a registered in-window flag.

There are two ways to clear the divider. A direct clear input that is held low keeps the count at zero. A reference burst pulse clears the count only while its own clear-enable input is high. Every input passes through a two-stage synchronizer clocked by the 8x clock. An input change driven between two rising edges therefore acts at the third rising edge after it.

The line comparator is a two-state machine. In LW_IDLE it waits for the advance gate to rise. On that rising edge it records the current count and whether a tick falls on that same edge, then moves to LW_OPEN. In LW_OPEN it keeps collecting ticks. When the delay gate rises it makes its decision, updates both flags and returns to LW_IDLE. A delay-gate rise seen in LW_IDLE is ignored, and so is an advance-gate rise seen in LW_OPEN.

Top module: `sc_phase_top`

## Requirements
- R1: Every input passes through a two-stage synchronizer. An input change driven between two rising clock edges first acts on the design's state at the third rising edge after the change.
- R2: The count advances by one on each clock edge, modulo 8. `sc_ref` is high while the count is 4 to 7 and low while it is 0 to 3, so it has a period of 8 clocks.
- R3: While the synchronized direct clear is low, the count is forced to 0 and `sc_ref` stays low. After release, the first counting edge takes the count to 1.
- R4: While the synchronized reference burst and the synchronized clear-enable are both high, the next edge forces the count to 0.
- R5: While clear-enable is low, a reference burst pulse leaves the count sequence unchanged.
- R6: The window runs from the advance-gate rising edge to the delay-gate rising edge, both edges included. If a tick (a 7-to-0 rollover by counting) falls inside it, then at the delay-gate rising edge `in_win_n` goes to 0 and `early_n` goes to 1.
- R7: If no tick falls inside the window, and the count recorded at the advance-gate rising edge is below 4, then `early_n` goes to 0 and `in_win_n` goes to 1.
- R8: If no tick falls inside the window and the recorded count is 4 or more, both flags go to 1.
- R9: The flags change only at a delay-gate rising edge that closes a window. Between such edges they hold their values.
- R10: `brst_ph_n` goes low for one clock after each tick edge at which the synchronized advance burst gate is high. `brst_ph_p` does the same for the delay burst gate. Neither output goes low when no tick falls inside its gate.
- R11: While the synchronized `brst_out_en` is low, both burst phase outputs stay high.
- R12: During reset `early_n`, `in_win_n`, `brst_ph_n` and `brst_ph_p` are 1, and `sc_ref` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk8 | input | 1 | Clock at 8x the subcarrier rate |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ctr_clr_n | input | 1 | Direct divider clear, active low |
| ref_burst | input | 1 | Reference burst pulse that clears the divider |
| ref_clr_en | input | 1 | High lets `ref_burst` clear the divider |
| brst_adv | input | 1 | Advance burst gate |
| brst_dly | input | 1 | Delay burst gate |
| brst_out_en | input | 1 | High enables the burst phase outputs |
| line_adv | input | 1 | Advance line-rate gate; its rising edge opens the window |
| line_dly | input | 1 | Delay line-rate gate; its rising edge closes the window |
| sc_ref | output | 1 | Divided subcarrier reference, high for counts 4 to 7 |
| brst_ph_n | output | 1 | Active-low pulse: tick inside the advance burst gate |
| brst_ph_p | output | 1 | Active-low pulse: tick inside the delay burst gate |
| early_n | output | 1 | Active-low flag: tick came shortly before the window |
| in_win_n | output | 1 | Active-low flag: tick fell inside the window |

## Verification
The hardest cases to reach from the ports are a tick that falls exactly on the advance-gate edge or exactly on the delay-gate edge, and a recorded count that sits exactly on the early/late boundary of 3 versus 4. The tick is internal, and every gate is delayed by the synchronizer. The stimulus first pulses the direct clear, which puts the count at a known phase. It then raises each gate a counted number of cycles later. The expected tick positions follow from the three-edge input latency and the modulo-8 count.

// File: rtl/sc_phase_pkg.sv
package sc_phase_pkg;

    // Positions of the inputs inside the synchronizer vector
    localparam int IDX_CLR   = 0;
    localparam int IDX_REF   = 1;
    localparam int IDX_REFEN = 2;
    localparam int IDX_BADV  = 3;
    localparam int IDX_BDLY  = 4;
    localparam int IDX_BEN   = 5;
    localparam int IDX_LADV  = 6;
    localparam int IDX_LDLY  = 7;
    localparam int N_IN      = 8;

    // States of the line-rate window comparator
    typedef enum logic [0:0] {
        LW_IDLE = 1'b0,
        LW_OPEN = 1'b1
    } lw_state_e;

endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                stg[k] <= '0;
            end
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                stg[k] <= stg[k-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/sc_divider.sv
module sc_divider #(
    parameter int DIV = 8,
    parameter int CW  = $clog2(DIV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_n,
    input  logic          ref_pulse,
    input  logic          ref_en,
    output logic [CW-1:0] cnt,
    output logic          tick,
    output logic          sc_ref
);

    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic hold_zero;

    always_comb begin
        hold_zero = (!clr_n) || (ref_pulse && ref_en);
        tick      = (!hold_zero) && (cnt == LAST);
        sc_ref    = (cnt >= HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!clr_n) begin
            cnt <= '0;                     // direct clear wins
        end else if (ref_pulse && ref_en) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/sc_burst_cmp.sv
module sc_burst_cmp (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic gate_adv,
    input  logic gate_dly,
    input  logic out_en,
    output logic ph_n,
    output logic ph_p
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_n <= 1'b1;
            ph_p <= 1'b1;
        end else begin
            ph_n <= !(out_en && tick && gate_adv);
            ph_p <= !(out_en && tick && gate_dly);
        end
    end

endmodule

// File: rtl/sc_line_window.sv
module sc_line_window
    import sc_phase_pkg::*;
#(
    parameter int DIV = 8,
    parameter int CW  = $clog2(DIV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate_adv,
    input  logic          gate_dly,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    output logic          early_n,
    output logic          in_win_n,
    output logic          win_eval
);

    localparam logic [CW-1:0] EARLY_SPAN = CW'(DIV / 2);

    lw_state_e     state_q, state_d;
    logic          adv_q, dly_q;
    logic          adv_rise, dly_rise;
    logic          seen_q;
    logic [CW-1:0] cap_q;

    // Edge detection on the synchronized gates
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adv_q <= 1'b0;
            dly_q <= 1'b0;
        end else begin
            adv_q <= gate_adv;
            dly_q <= gate_dly;
        end
    end

    assign adv_rise = gate_adv & ~adv_q;
    assign dly_rise = gate_dly & ~dly_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d  = state_q;
        win_eval = 1'b0;
        unique case (state_q)
            LW_IDLE: begin
                if (adv_rise) begin
                    state_d = LW_OPEN;
                end
            end
            LW_OPEN: begin
                if (dly_rise) begin
                    state_d  = LW_IDLE;
                    win_eval = 1'b1;
                end
            end
            default: state_d = LW_IDLE;
        endcase
    end

    // Window bookkeeping and registered flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q   <= 1'b0;
            cap_q    <= '0;
            early_n  <= 1'b1;
            in_win_n <= 1'b1;
        end else begin
            if (state_q == LW_IDLE && adv_rise) begin
                seen_q <= tick;
                cap_q  <= cnt;
            end else if (state_q == LW_OPEN) begin
                seen_q <= seen_q | tick;
            end
            if (win_eval) begin
                if (seen_q || tick) begin
                    early_n  <= 1'b1;
                    in_win_n <= 1'b0;
                end else if (cap_q < EARLY_SPAN) begin
                    early_n  <= 1'b0;
                    in_win_n <= 1'b1;
                end else begin
                    early_n  <= 1'b1;
                    in_win_n <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sc_phase_top.sv
module sc_phase_top
    import sc_phase_pkg::*;
#(
    parameter int DIV         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk8,
    input  logic rst_n,
    input  logic ctr_clr_n,
    input  logic ref_burst,
    input  logic ref_clr_en,
    input  logic brst_adv,
    input  logic brst_dly,
    input  logic brst_out_en,
    input  logic line_adv,
    input  logic line_dly,
    output logic sc_ref,
    output logic brst_ph_n,
    output logic brst_ph_p,
    output logic early_n,
    output logic in_win_n
);

    localparam int CW = $clog2(DIV);

    logic [N_IN-1:0] raw_in, syn_in;
    logic            clr_s, ref_s, refen_s, badv_s, bdly_s, ben_s, ladv_s, ldly_s;
    logic [CW-1:0]   sc_cnt;
    logic            sc_tick;
    logic            win_eval;

    always_comb begin
        raw_in            = '0;
        raw_in[IDX_CLR]   = ctr_clr_n;
        raw_in[IDX_REF]   = ref_burst;
        raw_in[IDX_REFEN] = ref_clr_en;
        raw_in[IDX_BADV]  = brst_adv;
        raw_in[IDX_BDLY]  = brst_dly;
        raw_in[IDX_BEN]   = brst_out_en;
        raw_in[IDX_LADV]  = line_adv;
        raw_in[IDX_LDLY]  = line_dly;
    end

    sc_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk8),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign clr_s   = syn_in[IDX_CLR];
    assign ref_s   = syn_in[IDX_REF];
    assign refen_s = syn_in[IDX_REFEN];
    assign badv_s  = syn_in[IDX_BADV];
    assign bdly_s  = syn_in[IDX_BDLY];
    assign ben_s   = syn_in[IDX_BEN];
    assign ladv_s  = syn_in[IDX_LADV];
    assign ldly_s  = syn_in[IDX_LDLY];

    sc_divider #(.DIV(DIV), .CW(CW)) u_div (
        .clk       (clk8),
        .rst_n     (rst_n),
        .clr_n     (clr_s),
        .ref_pulse (ref_s),
        .ref_en    (refen_s),
        .cnt       (sc_cnt),
        .tick      (sc_tick),
        .sc_ref    (sc_ref)
    );

    sc_burst_cmp u_burst (
        .clk      (clk8),
        .rst_n    (rst_n),
        .tick     (sc_tick),
        .gate_adv (badv_s),
        .gate_dly (bdly_s),
        .out_en   (ben_s),
        .ph_n     (brst_ph_n),
        .ph_p     (brst_ph_p)
    );

    sc_line_window #(.DIV(DIV), .CW(CW)) u_line (
        .clk      (clk8),
        .rst_n    (rst_n),
        .gate_adv (ladv_s),
        .gate_dly (ldly_s),
        .tick     (sc_tick),
        .cnt      (sc_cnt),
        .early_n  (early_n),
        .in_win_n (in_win_n),
        .win_eval (win_eval)
    );

endmodule

// File: rtl/sc_phase_chk.sv
module sc_phase_chk #(
    parameter int DIV = 8,
    parameter int CW  = $clog2(DIV)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr_s,
    input logic          ref_s,
    input logic          refen_s,
    input logic          badv_s,
    input logic          bdly_s,
    input logic          ben_s,
    input logic          tick,
    input logic          win_eval,
    input logic [CW-1:0] cnt,
    input logic          brst_ph_n,
    input logic          brst_ph_p,
    input logic          early_n,
    input logic          in_win_n
);

    // R3
    clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> (cnt == '0));

    // R4
    ref_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s && ref_s && refen_s) |=> (cnt == '0));

    // R2 R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s && !(ref_s && refen_s)) |=> (cnt == $past(cnt) + CW'(1)));

    // R11
    burst_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ben_s |=> (brst_ph_n && brst_ph_p));

    // R10
    ph_n_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !brst_ph_n |-> $past(tick && badv_s));

    // R10
    ph_p_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !brst_ph_p |-> $past(tick && bdly_s));

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(win_eval) |-> ($stable(early_n) && $stable(in_win_n)));

    // R6
    in_win_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_win_n) |-> $past(win_eval));

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !early_n |-> in_win_n);

endmodule

bind sc_phase_top sc_phase_chk #(.DIV(DIV), .CW(CW)) u_chk (
    .clk       (clk8),
    .rst_n     (rst_n),
    .clr_s     (clr_s),
    .ref_s     (ref_s),
    .refen_s   (refen_s),
    .badv_s    (badv_s),
    .bdly_s    (bdly_s),
    .ben_s     (ben_s),
    .tick      (sc_tick),
    .win_eval  (win_eval),
    .cnt       (sc_cnt),
    .brst_ph_n (brst_ph_n),
    .brst_ph_p (brst_ph_p),
    .early_n   (early_n),
    .in_win_n  (in_win_n)
);

// File: tb/tb_sc_phase_top.sv
module tb_sc_phase_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic clk8 = 1'b0;
    logic rst_n, ctr_clr_n, ref_burst, ref_clr_en;
    logic brst_adv, brst_dly, brst_out_en, line_adv, line_dly;
    logic sc_ref, brst_ph_n, brst_ph_p, early_n, in_win_n;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        string req;
        int    exp;
    } exp_item_t;

    exp_item_t expq[$];
    int        actq[$];

    always #(CLK_PERIOD/2) clk8 = ~clk8;

    sc_phase_top dut (
        .clk8        (clk8),
        .rst_n       (rst_n),
        .ctr_clr_n   (ctr_clr_n),
        .ref_burst   (ref_burst),
        .ref_clr_en  (ref_clr_en),
        .brst_adv    (brst_adv),
        .brst_dly    (brst_dly),
        .brst_out_en (brst_out_en),
        .line_adv    (line_adv),
        .line_dly    (line_dly),
        .sc_ref      (sc_ref),
        .brst_ph_n   (brst_ph_n),
        .brst_ph_p   (brst_ph_p),
        .early_n     (early_n),
        .in_win_n    (in_win_n)
    );

    // Driver side: expected item and observed value enter the scoreboard
    task automatic push_check(string req, int exp, int act);
        exp_item_t it;
        it.req = req;
        it.exp = exp;
        expq.push_back(it);
        actq.push_back(act);
    endtask

    // Monitor: pops pairs and compares
    initial begin
        forever begin
            @(negedge clk8);
            while (expq.size() > 0 && actq.size() > 0) begin
                exp_item_t it;
                int        act;
                it  = expq.pop_front();
                act = actq.pop_front();
                total++;
                if (act != it.exp) begin
                    fails++;
                    $display("FAIL %s: actual %0d expected %0d", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk8);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            report();
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk8);
    endtask

    // After this task the count is 0 and advances by one per edge (R1, R3):
    // at the k-th falling edge from here the count is k mod 8.
    task automatic align();
        ctr_clr_n = 1'b0;
        step(4);
        ctr_clr_n = 1'b1;
        step(2);
    endtask

    // A gate driven k cycles after align meets count (k+2) mod 8 at the edge
    // where it first acts; a tick there means count 7 (R1).
    function automatic bit tick_at(int k);
        return ((k + 2) % 8) == 7;
    endfunction

    // {early_n, in_win_n} expected for advance at a, delay at d (R6 R7 R8)
    function automatic int line_exp(int a, int d);
        bit hit = 1'b0;
        for (int j = a; j <= d; j++) begin
            if (tick_at(j)) hit = 1'b1;
        end
        if (hit) return 2;
        if (((a + 2) % 8) < 4) return 1;
        return 3;
    endfunction

    function automatic int burst_exp(int a, int w);
        int n = 0;
        for (int j = a; j < a + w; j++) begin
            if (tick_at(j)) n++;
        end
        return n;
    endfunction

    task automatic line_case(string req, int a, int d);
        align();
        step(a);
        line_adv = 1'b1;
        step(1);
        line_adv = 1'b0;
        step(d - a - 1);
        line_dly = 1'b1;
        step(1);
        line_dly = 1'b0;
        step(5);
        push_check(req, line_exp(a, d), int'({early_n, in_win_n}));
    endtask

    task automatic burst_case(string req, bit use_dly, int a, int w, bit en);
        int ln = 0;
        int lp = 0;
        int e;
        brst_out_en = en;
        align();
        step(a);
        if (use_dly) brst_dly = 1'b1;
        else         brst_adv = 1'b1;
        for (int i = 0; i < w + 8; i++) begin
            if (i == w) begin
                brst_adv = 1'b0;
                brst_dly = 1'b0;
            end
            step(1);
            if (!brst_ph_n) ln++;
            if (!brst_ph_p) lp++;
        end
        e = en ? burst_exp(a, w) : 0;
        push_check({req, " ph_n"}, use_dly ? 0 : e, ln);
        push_check({req, " ph_p"}, use_dly ? e : 0, lp);
    endtask

    task automatic ref_case(string req, bit en, int r);
        logic [7:0] got = '0;
        logic [7:0] exp = '0;
        ref_clr_en = en;
        align();
        step(r);
        ref_burst = 1'b1;
        step(1);
        ref_burst = 1'b0;
        step(2);
        for (int k = 0; k < 8; k++) begin
            got[k] = sc_ref;
            exp[k] = en ? (k >= 4) : (((r + 3 + k) % 8) >= 4);
            step(1);
        end
        push_check(req, int'(exp), int'(got));
    endtask

    initial begin
        rst_n       = 1'b0;
        ctr_clr_n   = 1'b0;
        ref_burst   = 1'b0;
        ref_clr_en  = 1'b0;
        brst_adv    = 1'b0;
        brst_dly    = 1'b0;
        brst_out_en = 1'b0;
        line_adv    = 1'b0;
        line_dly    = 1'b0;

        step(3);
        // R12: early_n, in_win_n, ph_n, ph_p high; sc_ref low
        push_check("R12 reset outputs", 5'b11110,
                   int'({early_n, in_win_n, brst_ph_n, brst_ph_p, sc_ref}));
        rst_n = 1'b1;
        step(3);
        push_check("R12 after release", 5'b11110,
                   int'({early_n, in_win_n, brst_ph_n, brst_ph_p, sc_ref}));

        // R2 and R1: sc_ref pattern over two periods after alignment
        begin
            logic [15:0] got = '0;
            logic [15:0] exp = '0;
            align();
            for (int k = 0; k < 16; k++) begin
                got[k] = sc_ref;
                exp[k] = (k % 8) >= 4;
                step(1);
            end
            push_check("R2 divide-by-8 pattern", int'(exp), int'(got));
        end

        // R3: direct clear holds the count, sc_ref never rises
        begin
            int highs = 0;
            ctr_clr_n = 1'b0;
            step(4);
            for (int k = 0; k < 12; k++) begin
                if (sc_ref) highs++;
                step(1);
            end
            push_check("R3 clear holds count", 0, highs);
            ctr_clr_n = 1'b1;
        end

        ref_case("R4 reference burst clears", 1'b1, 3);
        ref_case("R5 reference burst ignored", 1'b0, 3);

        line_case("R6 tick inside window", 3, 6);
        line_case("R6 tick on delay edge", 3, 5);
        line_case("R6 tick on advance edge", 5, 7);
        line_case("R7 early, count 2", 0, 2);
        line_case("R7 early, count 3 boundary", 1, 3);
        // R9: no delay edge, flags unchanged despite burst activity
        brst_out_en = 1'b1;
        step(4);
        brst_adv = 1'b1;
        step(20);
        brst_adv = 1'b0;
        push_check("R9 flags hold", 1, int'({early_n, in_win_n}));
        line_case("R8 late, count 4 boundary", 2, 4);
        line_case("R8 late, count 5", 11, 12);

        burst_case("R10 advance gate hit", 1'b0, 4, 3, 1'b1);
        burst_case("R10 delay gate hit", 1'b1, 12, 2, 1'b1);
        burst_case("R10 no tick in gate", 1'b0, 0, 3, 1'b1);
        burst_case("R10 long gate two ticks", 1'b1, 2, 16, 1'b1);
        burst_case("R11 outputs inhibited", 1'b0, 4, 3, 1'b0);

        step(3);
        done = 1'b1;
        report();
    end

endmodule